// File: doc/BRIEF.md
# Aligning Instruction Prefetch Buffer

This block sits between a 32-bit instruction memory port and the decode stage. It fetches whole words in sequence, keeps up to two of them, and presents the decode stage with one instruction at a time. Each instruction is either 16-bit (compressed) or 32-bit, so an instruction may start on any halfword. A 32-bit instruction that starts in the upper half of a word is assembled from that word and the next one. Compressed instructions are passed on unexpanded, zero-extended into the upper half.

A later stage can redirect the fetch by raising `redirect_i` for one cycle with the new PC. This empties the buffer. Responses that are still outstanding for requests issued before the redirect are counted and dropped when they arrive. In the same cycle, the word holding the target is requested. A response word can be used in the cycle it arrives, so a zero-wait memory sustains one instruction per cycle. A 32-bit target in the upper half of a word needs a second word first, and so costs one more cycle than a word-aligned target.

The memory port uses a request/grant handshake. Responses come back in order, at least one cycle after their grant. The decode side uses a valid/ready handshake.

Top module: `pf_prefetch_align`

## Requirements
- R1: After reset `instr_valid_o` is low, and the block requests the word that holds `BOOT_ADDR` (address with bits 1:0 cleared), with the PC starting at `BOOT_ADDR`.
- R2: A 32-bit instruction at a word-aligned PC is delivered as the whole word on `instr_o`, with its address on `instr_pc_o`, and the next PC is that address plus 4.
- R3: A compressed instruction is delivered as its halfword in `instr_o[15:0]` with `instr_o[31:16]` zero, and the next PC is its address plus 2.
- R4: A 32-bit instruction at PC bit 1 = 1 is delivered as {low half of the following word, upper half of the current word}.
- R5: A halfword is the start of a 32-bit instruction when its bits 1:0 equal 2'b11; any other value marks a 16-bit instruction.
- R6: In a redirect cycle `instr_valid_o` is low and, while fewer than `OUT_MAX` requests are outstanding, `mem_req_o` is high with `mem_addr_o` equal to the redirect PC with bits 1:0 cleared.
- R7: After a redirect, all buffered words and every response to a request granted before or during the redirect's flush are discarded, and the first instruction delivered carries the redirect PC.
- R8: With a zero-wait memory, a word-aligned target is valid one cycle after the redirect cycle, and a 32-bit target at PC bit 1 = 1 is valid two cycles after it.
- R9: While `instr_valid_o` is high and `instr_ready_i` is low, the same instruction and PC stay presented until a redirect.
- R10: Words buffered plus requests granted since the last redirect and not yet answered never exceed two.
- R11: With a zero-wait memory that grants every request and `instr_ready_i` held high, `instr_valid_o` stays high every cycle in steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| redirect_i | input | 1 | Flush and restart fetching at `redirect_pc_i` |
| redirect_pc_i | input | 32 | Redirect target, halfword aligned |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | 32 | Word address of the request |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Response data valid, in request order |
| mem_rdata_i | input | 32 | Response word |
| instr_valid_o | output | 1 | An instruction is presented |
| instr_ready_i | input | 1 | Decode accepts the presented instruction |
| instr_o | output | 32 | Instruction, compressed ones zero-extended |
| instr_pc_o | output | 32 | Address of the presented instruction |

## Verification
The assertions check on every cycle that buffered plus live in-flight words stay within two, that the discard count never exceeds the outstanding count, that a redirect issues the target word request at once, and that a stalled output holds still. Whether realigned and compressed instructions are assembled correctly, whether stale responses are really dropped, and how many cycles a redirect costs for aligned and misaligned targets can only be seen in the bench's scenarios. The bench compares every accepted instruction against a halfword reference stream.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef logic [31:0] word_t;
  typedef logic [15:0] half_t;

  // 32-bit encoding when both low bits are set
  function automatic logic is_wide(input half_t h);
    return h[1:0] == 2'b11;
  endfunction
endpackage

// File: rtl/pf_word_buf.sv
module pf_word_buf
  import pf_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  word_t            wdata_i,
  output word_t            data_o [DEPTH],
  output logic [CNT_W-1:0] count_o
);
  word_t            ent_q [DEPTH];
  word_t            ent_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) ent_d[i] = ent_q[i];
    cnt_d = cnt_q;
    if (pop_i && cnt_q != '0) begin
      for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i + 1];
      cnt_d = cnt_q - 1'b1;
    end
    // pop with an empty buffer consumes the incoming word directly
    if (push_i && !(pop_i && cnt_q == '0)) begin
      for (int i = 0; i < DEPTH; i++)
        if (i == int'(cnt_d)) ent_d[i] = wdata_i;
      cnt_d = cnt_d + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_d[i];
    end
  end

  assign data_o  = ent_q;
  assign count_o = cnt_q;

  p_no_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !clear_i) |-> (cnt_q < CNT_W'(DEPTH)));

  p_pop_has_word_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !clear_i) |-> (cnt_q != '0 || push_i));

  p_clear_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cnt_q == '0));
endmodule

// File: rtl/pf_fetch_seq.sv
module pf_fetch_seq
  import pf_pkg::*;
#(
  parameter word_t       BOOT_ADDR = 32'h0000_0080,
  parameter int unsigned DEPTH     = 2,
  parameter int unsigned CNT_W     = $clog2(DEPTH + 1),
  parameter int unsigned OUT_MAX   = 4,
  parameter int unsigned OUT_W     = $clog2(OUT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             redirect_i,
  input  word_t            redirect_pc_i,
  input  logic [CNT_W-1:0] buf_count_i,
  input  logic             pop_i,
  output logic             mem_req_o,
  output word_t            mem_addr_o,
  input  logic             mem_gnt_i,
  input  logic             mem_rvalid_i,
  output logic             resp_accept_o
);
  localparam int unsigned OCC_W = (OUT_W > CNT_W ? OUT_W : CNT_W) + 1;

  logic [OUT_W-1:0] out_q, drop_q, live;
  logic [OCC_W-1:0] occ;
  word_t            next_addr_q;
  logic             space_ok, cap_ok, fire;

  assign live = out_q - drop_q;

  always_comb begin
    occ      = OCC_W'(buf_count_i) + OCC_W'(live) - OCC_W'(pop_i);
    space_ok = redirect_i || (occ < OCC_W'(DEPTH));
    cap_ok   = out_q < OUT_W'(OUT_MAX);
  end

  assign mem_req_o     = space_ok && cap_ok;
  assign mem_addr_o    = redirect_i ? {redirect_pc_i[31:2], 2'b00} : next_addr_q;
  assign fire          = mem_req_o && mem_gnt_i;
  assign resp_accept_o = mem_rvalid_i && drop_q == '0 && !redirect_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q       <= '0;
      drop_q      <= '0;
      next_addr_q <= {BOOT_ADDR[31:2], 2'b00};
    end else begin
      out_q <= out_q + OUT_W'(fire) - OUT_W'(mem_rvalid_i);
      if (redirect_i)
        drop_q <= out_q - OUT_W'(mem_rvalid_i);
      else if (mem_rvalid_i && drop_q != '0)
        drop_q <= drop_q - 1'b1;
      if (fire)
        next_addr_q <= mem_addr_o + 32'd4;
      else if (redirect_i)
        next_addr_q <= mem_addr_o;
    end
  end

  p_space_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (OCC_W'(buf_count_i) + OCC_W'(live)) <= OCC_W'(DEPTH));

  p_drop_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_q <= out_q);

  p_redirect_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_i && out_q < OUT_W'(OUT_MAX)) |->
      (mem_req_o && mem_addr_o[1:0] == 2'b00 && mem_addr_o[31:2] == redirect_pc_i[31:2]));
endmodule

// File: rtl/pf_align.sv
module pf_align
  import pf_pkg::*;
#(
  parameter word_t       BOOT_ADDR = 32'h0000_0080,
  parameter int unsigned DEPTH     = 2,
  parameter int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             redirect_i,
  input  word_t            redirect_pc_i,
  input  word_t            buf_data_i [DEPTH],
  input  logic [CNT_W-1:0] buf_count_i,
  input  logic             resp_accept_i,
  input  word_t            resp_data_i,
  input  logic             ready_i,
  output logic             valid_o,
  output word_t            instr_o,
  output word_t            pc_o,
  output logic             pop_o
);
  word_t          pc_q, w0, w1;
  half_t          head;
  logic [CNT_W:0] avail;
  logic           wide, have, eats_word;

  always_comb begin
    avail = (CNT_W + 1)'(buf_count_i) + (CNT_W + 1)'(resp_accept_i);
    // window = buffered words followed by the word arriving now
    w0    = (buf_count_i != '0) ? buf_data_i[0] : resp_data_i;
    w1    = (buf_count_i > CNT_W'(1)) ? buf_data_i[1] : resp_data_i;
    head  = pc_q[1] ? w0[31:16] : w0[15:0];
    wide  = is_wide(head);
    if (!pc_q[1]) begin
      have      = avail != '0;
      eats_word = wide;
      instr_o   = wide ? w0 : {16'h0000, head};
    end else begin
      have      = wide ? (avail > (CNT_W + 1)'(1)) : (avail != '0);
      eats_word = 1'b1;
      instr_o   = wide ? {w1[15:0], head} : {16'h0000, head};
    end
  end

  assign valid_o = have && !redirect_i;
  assign pc_o    = pc_q;
  assign pop_o   = valid_o && ready_i && eats_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      pc_q <= BOOT_ADDR;
    else if (redirect_i)
      pc_q <= redirect_pc_i;
    else if (valid_o && ready_i)
      pc_q <= pc_q + (wide ? 32'd4 : 32'd2);
  end

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ready_i && !redirect_i) |=>
      (redirect_i || (valid_o && $stable(instr_o) && $stable(pc_o))));

  p_comp_zext_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && instr_o[1:0] != 2'b11) |-> (instr_o[31:16] == 16'h0000));
endmodule

// File: rtl/pf_prefetch_align.sv
module pf_prefetch_align
  import pf_pkg::*;
#(
  parameter word_t       BOOT_ADDR = 32'h0000_0080,
  parameter int unsigned OUT_MAX   = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        redirect_i,
  input  logic [31:0] redirect_pc_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        instr_valid_o,
  input  logic        instr_ready_i,
  output logic [31:0] instr_o,
  output logic [31:0] instr_pc_o
);
  localparam int unsigned BUF_WORDS = 2;
  localparam int unsigned CNT_W     = $clog2(BUF_WORDS + 1);
  localparam int unsigned OUT_W     = $clog2(OUT_MAX + 1);

  word_t            buf_data [BUF_WORDS];
  logic [CNT_W-1:0] buf_count;
  logic             pop, resp_accept;

  pf_fetch_seq #(
    .BOOT_ADDR(BOOT_ADDR), .DEPTH(BUF_WORDS), .CNT_W(CNT_W),
    .OUT_MAX(OUT_MAX), .OUT_W(OUT_W)
  ) u_fetch (
    .clk_i, .rst_ni,
    .redirect_i, .redirect_pc_i,
    .buf_count_i  (buf_count),
    .pop_i        (pop),
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i,
    .resp_accept_o(resp_accept)
  );

  pf_word_buf #(.DEPTH(BUF_WORDS), .CNT_W(CNT_W)) u_buf (
    .clk_i, .rst_ni,
    .clear_i (redirect_i),
    .push_i  (resp_accept),
    .pop_i   (pop),
    .wdata_i (mem_rdata_i),
    .data_o  (buf_data),
    .count_o (buf_count)
  );

  pf_align #(.BOOT_ADDR(BOOT_ADDR), .DEPTH(BUF_WORDS), .CNT_W(CNT_W)) u_align (
    .clk_i, .rst_ni,
    .redirect_i, .redirect_pc_i,
    .buf_data_i   (buf_data),
    .buf_count_i  (buf_count),
    .resp_accept_i(resp_accept),
    .resp_data_i  (mem_rdata_i),
    .ready_i      (instr_ready_i),
    .valid_o      (instr_valid_o),
    .instr_o,
    .pc_o         (instr_pc_o),
    .pop_o        (pop)
  );

  p_flush_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_i |-> !instr_valid_o);
endmodule

// File: tb/tb_pf_prefetch_align.sv
`timescale 1ns/1ps
module tb_pf_prefetch_align;
  localparam logic [31:0] BOOT = 32'h0000_0080;
  localparam int OUT_MAX = 4;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        redirect_i = 1'b0;
  logic [31:0] redirect_pc_i = '0;
  logic        mem_req_o, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;
  logic        instr_valid_o, instr_ready_i = 1'b0;
  logic [31:0] instr_o, instr_pc_o;

  always #5 clk = ~clk;

  pf_prefetch_align #(.BOOT_ADDR(BOOT), .OUT_MAX(OUT_MAX)) dut (
    .clk_i(clk), .rst_ni, .redirect_i, .redirect_pc_i,
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .instr_valid_o, .instr_ready_i, .instr_o, .instr_pc_o
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // program image: one pseudo-random halfword per address
  function automatic logic [15:0] hw(input logic [31:0] a);
    logic [31:0] x;
    x = (a ^ 32'h5bd1_e995) * 32'h9e37_79b1;
    x = x ^ (x >> 15);
    return x[15:0];
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {hw(a + 32'd2), hw(a)};
  endfunction

  function automatic logic [31:0] exp_instr(input logic [31:0] pc);
    logic [15:0] lo;
    lo = hw(pc);
    return (lo[1:0] == 2'b11) ? {hw(pc + 32'd2), lo} : {16'h0000, lo};  // R5 length rule
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model state
  logic [31:0] q_addr [8];
  int          q_ep   [8];
  int q_hd = 0, q_tl = 0, q_n = 0, epoch = 0;
  logic [31:0] ref_pc = BOOT;
  bit first_after = 0, obs_valid = 0;
  bit hold_pend = 0;
  logic [31:0] hold_instr, hold_pc;

  task automatic do_cycle(input bit rd, input logic [31:0] tgt, input bit rdy, input bit fast);
    int start_n, live;
    bit rv, g;
    string tag;
    @(negedge clk);
    start_n = q_n;
    rv = (q_n > 0) && (fast || ($urandom % 10 < 6));
    g  = fast || ($urandom % 10 < 7);
    redirect_i    = rd;
    redirect_pc_i = tgt;
    instr_ready_i = rdy;
    mem_gnt_i     = g;
    mem_rvalid_i  = rv;
    mem_rdata_i   = rv ? mem_word(q_addr[q_hd]) : 32'h0;
    if (rd) epoch++;
    #1;
    obs_valid = instr_valid_o;
    if (rd) begin
      check(!instr_valid_o, "R6", {31'd0, instr_valid_o}, 32'd0);
      if (start_n < OUT_MAX) begin
        check(mem_req_o, "R6", {31'd0, mem_req_o}, 32'd1);
        check(mem_addr_o == {tgt[31:2], 2'b00}, "R6", mem_addr_o, {tgt[31:2], 2'b00});
      end
      ref_pc = tgt;
      first_after = 1;
    end
    if (hold_pend && !rd) begin  // R9
      check(instr_valid_o && instr_o == hold_instr, "R9", instr_o, hold_instr);
      check(instr_pc_o == hold_pc, "R9", instr_pc_o, hold_pc);
    end
    hold_pend = instr_valid_o && !rdy && !rd;
    hold_instr = instr_o;
    hold_pc = instr_pc_o;
    if (instr_valid_o && rdy && !rd) begin
      if (first_after) tag = "R7";
      else if (exp_instr(ref_pc)[1:0] != 2'b11) tag = "R3";
      else if (ref_pc[1]) tag = "R4";
      else tag = "R2";
      check(instr_pc_o == ref_pc, tag, instr_pc_o, ref_pc);
      check(instr_o == exp_instr(ref_pc), tag, instr_o, exp_instr(ref_pc));
      ref_pc = ref_pc + ((exp_instr(ref_pc)[1:0] == 2'b11) ? 32'd4 : 32'd2);
      first_after = 0;
    end
    if (rv) begin q_hd = (q_hd + 1) % 8; q_n--; end
    if (mem_req_o && g) begin
      q_addr[q_tl] = mem_addr_o; q_ep[q_tl] = epoch;
      q_tl = (q_tl + 1) % 8; q_n++;
    end
    live = 0;
    for (int i = 0; i < q_n; i++) if (q_ep[(q_hd + i) % 8] == epoch) live++;
    if (live > 2) check(0, "R10", live, 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] mis_t, al_t;
    int n, gaps;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    #1;
    // R1: reset state, nothing granted yet
    check(!instr_valid_o, "R1", {31'd0, instr_valid_o}, 32'd0);
    check(mem_req_o, "R1", {31'd0, mem_req_o}, 32'd1);
    check(mem_addr_o == {BOOT[31:2], 2'b00}, "R1", mem_addr_o, {BOOT[31:2], 2'b00});
    check(instr_pc_o == BOOT, "R1", instr_pc_o, BOOT);

    // R11: zero-wait memory, ready high, steady state
    gaps = 0;
    for (int i = 0; i < 80; i++) begin
      do_cycle(0, 32'h0, 1, 1);
      if (i >= 20 && !obs_valid) gaps++;
    end
    check(gaps == 0, "R11", gaps, 32'd0);

    // find redirect targets
    mis_t = 32'h0000_0402;
    while (!(mis_t[1] && hw(mis_t)[1:0] == 2'b11)) mis_t = mis_t + 32'd4;
    al_t = 32'h0000_0800;

    // R8: aligned target latency
    do_cycle(1, al_t, 1, 1);
    n = 0;
    do begin do_cycle(0, 32'h0, 1, 1); n++; end while (!obs_valid && n < 10);
    check(n == 1, "R8", n, 32'd1);
    repeat (10) do_cycle(0, 32'h0, 1, 1);
    // R8: misaligned 32-bit target needs one more cycle
    do_cycle(1, mis_t, 1, 1);
    n = 0;
    do begin do_cycle(0, 32'h0, 1, 1); n++; end while (!obs_valid && n < 10);
    check(n == 2, "R8", n, 32'd2);
    repeat (10) do_cycle(0, 32'h0, 1, 1);

    // R9 directed: stall the consumer
    repeat (6) do_cycle(0, 32'h0, 0, 1);
    repeat (4) do_cycle(0, 32'h0, 1, 1);

    // back-to-back redirects with in-flight data (R7)
    do_cycle(1, mis_t + 32'd16, 1, 0);
    do_cycle(1, al_t + 32'd6, 1, 0);
    repeat (20) do_cycle(0, 32'h0, 1, 0);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      bit fast, rd, rdy;
      fast = ((i / 500) % 2) == 0;
      rd   = ($urandom % 40) == 0;
      rdy  = ($urandom % 10) < 8;
      do_cycle(rd, 32'h0000_1000 + (($urandom % 2048) * 2), rdy, fast);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule